// File: doc/BRIEF.md
# Calibrated Temperature Conversion with Group Maximum

This block turns 12-bit raw codes from on-die temperature sensors into signed millidegrees Celsius. It applies a fixed-point formula whose divisors come from per-device calibration: a gain error, a per-sensor offset, a reference temperature, a slope trim with its sign, and a per-chip slope constant. When no calibration is present, `cal_valid` is held low and the block falls back to built-in defaults.

Samples arrive as (sensor index, raw code) pairs with a last-of-group marker. Each sample produces one converted temperature. The last sample of a group also yields the group maximum. Readings above a plausibility limit are counted as zero in the maximum, so that a bogus first reading cannot raise it. A single shared signed divider runs the two divisions of every sample one after the other.

The `busy` output is high while a sample is in flight. Samples offered while `busy` is high are dropped. A zero divisor counts as a fault: that sample's result is 0 and `out_err` is raised with it.

The control FSM has three states:
- IDLE: waits for a sample. On `in_valid` it latches the sample, starts the first division and moves to DIV_SLOPE.
- DIV_SLOPE: waits for the first division. On a zero-divisor fault it emits the fault result and returns to IDLE. Otherwise it starts the second division and moves to DIV_GAIN.
- DIV_GAIN: waits for the second division. It then emits the result and returns to IDLE.

Top module: `thermo_cal_conv`

## Requirements
- R1: Only bits [11:0] of `in_raw` take part in the conversion. Bits [15:12] have no effect on `out_temp`.
- R2: The conversion term is computed in this order, all in signed 32-bit arithmetic:
  1. Divide 1627604160 (that is, 203450520·8) by (slope constant + signed trim), truncating toward zero.
  2. Divide that by (10000 + gain error), truncating toward zero.
  3. Multiply by (raw − sensor offset − 3350).
  4. Shift arithmetically right by 3.
- R3: `out_temp` equals reference·500 minus the R2 term. It is reported unclamped.
- R4: The signed trim is the 6-bit magnitude, negated only when `cal_trim_sign` and `cal_chip_id` are both 1.
- R5: With `cal_valid` low, the block uses gain error 512, offset 260 for every sensor, reference 40 and trim 0. `slope_const` is still taken from its port.
- R6: Sensor `k` (k < NSENS) uses the 9-bit offset at bits [9k+8:9k] of `cal_sensor_off`. An index of NSENS or above uses offset 260.
- R7: A sample is accepted on a rising edge where `in_valid` is high and `busy` is low. For a non-fault sample:
  - `busy` is high from the following cycle until `out_valid`.
  - `out_valid` is a one-cycle pulse, visible in the 66th cycle after the accepting edge.
- R8: `in_valid` while `busy` is high is ignored: no extra result appears, and the in-flight result is unchanged.
- R9: When (slope constant + trim) is zero:
  - the result appears one cycle after acceptance, with `out_temp` = 0 and `out_err` = 1;
  - that 0 enters the group maximum.
  `out_err` is 0 on every other result.
- R10: Before comparison, a converted value above 200000 is replaced by 0. A value of exactly 200000 is kept.
- R11: On the result of a sample accepted with `in_last` = 1, `out_max_valid` pulses together with `out_valid`. `out_max` is then the maximum of the group's clamped values. The running maximum restarts from −2^31 for the next group.
- R12: During reset, every output is 0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_valid | input | 1 | Calibration present; low selects the defaults |
| cal_gain_err | input | 10 | Gain error (unsigned) |
| cal_sensor_off | input | NSENS·9 | Packed per-sensor offsets, sensor k at bits [9k+8:9k] |
| cal_ref_temp | input | 6 | Reference temperature |
| cal_trim_mag | input | 6 | Slope trim magnitude |
| cal_trim_sign | input | 1 | Slope trim sign bit |
| cal_chip_id | input | 1 | Chip identity bit that enables the sign |
| slope_const | input | 8 | Per-chip slope constant (165 or 153 typical) |
| in_valid | input | 1 | Sample offered |
| in_idx | input | IDX_W | Sensor index of the sample |
| in_raw | input | 16 | Raw sensor code; low 12 bits used |
| in_last | input | 1 | Sample closes its group |
| busy | output | 1 | A sample is in flight; new samples are dropped |
| out_valid | output | 1 | One-cycle result strobe |
| out_temp | output | 32 | Converted temperature in millidegrees, two's complement |
| out_err | output | 1 | Result came from a zero divisor |
| out_max_valid | output | 1 | Group-maximum strobe, coincident with out_valid |
| out_max | output | 32 | Group maximum of clamped values, two's complement |

## Verification
A result is due in the 66th cycle after the accepting edge (32 steps per division plus hand-over and output registers). A zero-divisor result is due in the very next cycle. `out_max` is due in the same cycle as the result of the group's last sample. The bench model decides acceptance from its own count of the busy window, not from the design. It then arms a countdown of that exact length and compares `out_valid` and `busy` in the middle of every clock cycle. Value, error flag and group maximum are compared only in the cycle the countdown expires.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    localparam int RAW_IN_W = 16;
    localparam int RAW_W    = 12;
    localparam int OFF_W    = 9;
    localparam int GE_W     = 10;
    localparam int REF_W    = 6;
    localparam int TRIM_W   = 6;
    localparam int SLOPE_W  = 8;
    localparam int DATA_W   = 32;

    localparam logic signed [DATA_W-1:0] SCALED_NUM    = 32'sd1627604160;
    localparam logic signed [DATA_W-1:0] GAIN_BASE     = 32'sd10000;
    localparam logic signed [DATA_W-1:0] RAW_BIAS      = 32'sd3350;
    localparam logic signed [DATA_W-1:0] REF_MULT      = 32'sd500;
    localparam logic signed [DATA_W-1:0] PLAUSIBLE_MAX = 32'sd200000;
    localparam logic signed [DATA_W-1:0] TEMP_FLOOR    = {1'b1, {(DATA_W-1){1'b0}}};

    localparam logic [RAW_IN_W-1:0] RAW_MASK = RAW_IN_W'((1 << RAW_W) - 1);
    localparam logic [GE_W-1:0]     DFLT_GE  = GE_W'(512);
    localparam logic [OFF_W-1:0]    DFLT_OFF = OFF_W'(260);
    localparam logic [REF_W-1:0]    DFLT_REF = REF_W'(40);

    typedef enum logic [1:0] {
        S_IDLE,
        S_DIV_SLOPE,
        S_DIV_GAIN
    } conv_state_e;

endpackage

// File: rtl/thermo_sdiv.sv
module thermo_sdiv #(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] dividend,
    input  logic signed [W-1:0] divisor,
    output logic                done,
    output logic                div_zero,
    output logic signed [W-1:0] quotient
);

    localparam int CNT_W = $clog2(W) + 1;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0]     a_bits, b_bits, a_abs, b_abs;
    logic [W-1:0]     rem_q, mag_q, den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, neg_q;
    logic [W:0]       trial;
    logic             fits;
    logic [W-1:0]     rem_nx, mag_nx, mag_neg;

    assign a_bits = dividend;
    assign b_bits = divisor;
    assign a_abs  = a_bits[W-1] ? (~a_bits + ONE) : a_bits;
    assign b_abs  = b_bits[W-1] ? (~b_bits + ONE) : b_bits;

    // one restoring step: shift in the next dividend bit, subtract if it fits
    assign trial   = {rem_q, mag_q[W-1]} - {1'b0, den_q};
    assign fits    = ~trial[W];
    assign rem_nx  = fits ? trial[W-1:0] : {rem_q[W-2:0], mag_q[W-1]};
    assign mag_nx  = {mag_q[W-2:0], fits};
    assign mag_neg = ~mag_nx + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            mag_q    <= '0;
            den_q    <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
            neg_q    <= 1'b0;
            done     <= 1'b0;
            div_zero <= 1'b0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                if (b_bits == '0) begin
                    done     <= 1'b1;
                    div_zero <= 1'b1;
                    run_q    <= 1'b0;
                    quotient <= '0;
                end else begin
                    div_zero <= 1'b0;
                    run_q    <= 1'b1;
                    cnt_q    <= CNT_W'(W);
                    rem_q    <= '0;
                    mag_q    <= a_abs;
                    den_q    <= b_abs;
                    neg_q    <= a_bits[W-1] ^ b_bits[W-1];
                end
            end else if (run_q) begin
                rem_q <= rem_nx;
                mag_q <= mag_nx;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q    <= 1'b0;
                    done     <= 1'b1;
                    quotient <= neg_q ? $signed(mag_neg) : $signed(mag_nx);
                end
            end
        end
    end

    // R7: completion is a single-cycle event
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a zero divisor finishes at once with the fault flag
    a_r9_zero_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (start && divisor == '0) |=> (done && div_zero && quotient == '0));

endmodule

// File: rtl/thermo_peak.sv
module thermo_peak
    import thermo_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  logic                     last,
    input  logic signed [DATA_W-1:0] value,
    output logic                     peak_valid,
    output logic signed [DATA_W-1:0] peak
);

    logic signed [DATA_W-1:0] acc_q, clamped, cand;

    assign clamped = (value > PLAUSIBLE_MAX) ? '0 : value;
    assign cand    = (clamped > acc_q) ? clamped : acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= TEMP_FLOOR;
            peak       <= '0;
            peak_valid <= 1'b0;
        end else begin
            peak_valid <= upd & last;
            if (upd) begin
                if (last) begin
                    peak  <= cand;
                    acc_q <= TEMP_FLOOR;
                end else begin
                    acc_q <= cand;
                end
            end
        end
    end

    // R10: a reported maximum never exceeds the plausibility limit
    a_r10_peak_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        peak_valid |-> (peak <= PLAUSIBLE_MAX));

    // R11: the closing sample's clamped value is never above the reported peak
    a_r11_peak_covers_last: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && last) |=> (peak >= $past(clamped)));

endmodule

// File: rtl/thermo_cal_conv.sv
module thermo_cal_conv
    import thermo_pkg::*;
#(
    parameter int NSENS = 6,
    parameter int IDX_W = (NSENS > 1) ? $clog2(NSENS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cal_valid,
    input  logic [GE_W-1:0]        cal_gain_err,
    input  logic [NSENS*OFF_W-1:0] cal_sensor_off,
    input  logic [REF_W-1:0]       cal_ref_temp,
    input  logic [TRIM_W-1:0]      cal_trim_mag,
    input  logic                   cal_trim_sign,
    input  logic                   cal_chip_id,
    input  logic [SLOPE_W-1:0]     slope_const,
    input  logic                   in_valid,
    input  logic [IDX_W-1:0]       in_idx,
    input  logic [RAW_IN_W-1:0]    in_raw,
    input  logic                   in_last,
    output logic                   busy,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_temp,
    output logic                   out_err,
    output logic                   out_max_valid,
    output logic [DATA_W-1:0]      out_max
);

    conv_state_e state_q, state_nx;

    // ---------------- calibration selection ----------------
    logic [OFF_W-1:0]  off_tab [NSENS];
    logic [OFF_W-1:0]  off_sel;
    logic [GE_W-1:0]   ge_eff;
    logic [REF_W-1:0]  ref_eff;
    logic [TRIM_W-1:0] trim_eff;
    logic              trim_neg;
    logic signed [DATA_W-1:0] trim_s, slope_div, gain_div;

    for (genvar g = 0; g < NSENS; g++) begin : g_off
        assign off_tab[g] = cal_valid ? cal_sensor_off[g*OFF_W +: OFF_W] : DFLT_OFF;
    end

    always_comb begin
        off_sel = DFLT_OFF;
        for (int k = 0; k < NSENS; k++) begin
            if (in_idx == IDX_W'(k)) off_sel = off_tab[k];
        end
    end

    assign ge_eff    = cal_valid ? cal_gain_err : DFLT_GE;
    assign ref_eff   = cal_valid ? cal_ref_temp : DFLT_REF;
    assign trim_eff  = cal_valid ? cal_trim_mag : '0;
    assign trim_neg  = cal_valid & cal_trim_sign & cal_chip_id;
    assign trim_s    = trim_neg ? -$signed({{(DATA_W-TRIM_W){1'b0}}, trim_eff})
                                :  $signed({{(DATA_W-TRIM_W){1'b0}}, trim_eff});
    assign slope_div = $signed({{(DATA_W-SLOPE_W){1'b0}}, slope_const}) + trim_s;
    assign gain_div  = GAIN_BASE + $signed({{(DATA_W-GE_W){1'b0}}, ge_eff});

    // ---------------- latched sample ----------------
    logic [RAW_IN_W-1:0]      raw_q;
    logic [OFF_W-1:0]         off_q;
    logic [REF_W-1:0]         ref_q;
    logic                     last_q;
    logic signed [DATA_W-1:0] gain_div_q;

    // ---------------- shared divider ----------------
    logic                     accept, div_start, div_done, div_zero;
    logic signed [DATA_W-1:0] div_a, div_b, div_quo;

    assign accept    = (state_q == S_IDLE) && in_valid;
    assign div_start = accept || ((state_q == S_DIV_SLOPE) && div_done && !div_zero);
    assign div_a     = (state_q == S_IDLE) ? SCALED_NUM : div_quo;
    assign div_b     = (state_q == S_IDLE) ? slope_div  : gain_div_q;

    thermo_sdiv #(.W(DATA_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .div_zero (div_zero),
        .quotient (div_quo)
    );

    // ---------------- post-division arithmetic ----------------
    logic signed [DATA_W-1:0] diff, prod, term, base, conv, res_val;
    logic                     fault, res_we;

    assign diff  = $signed({{(DATA_W-RAW_IN_W){1'b0}}, raw_q})
                 - $signed({{(DATA_W-OFF_W){1'b0}}, off_q}) - RAW_BIAS;
    assign prod  = div_quo * diff;
    assign term  = prod >>> 3;
    assign base  = $signed({{(DATA_W-REF_W){1'b0}}, ref_q}) * REF_MULT;
    assign conv  = base - term;

    assign fault   = div_done && div_zero;
    assign res_we  = ((state_q == S_DIV_SLOPE) && fault) || ((state_q == S_DIV_GAIN) && div_done);
    assign res_val = fault ? '0 : conv;

    // ---------------- FSM ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:      if (in_valid) state_nx = S_DIV_SLOPE;
            S_DIV_SLOPE: if (div_done) state_nx = div_zero ? S_IDLE : S_DIV_GAIN;
            S_DIV_GAIN:  if (div_done) state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    assign busy = (state_q != S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q      <= '0;
            off_q      <= '0;
            ref_q      <= '0;
            last_q     <= 1'b0;
            gain_div_q <= '0;
            out_valid  <= 1'b0;
            out_temp   <= '0;
            out_err    <= 1'b0;
        end else begin
            out_valid <= res_we;
            out_err   <= res_we & fault;
            if (res_we) out_temp <= res_val;
            if (accept) begin
                raw_q      <= in_raw & RAW_MASK;
                off_q      <= off_sel;
                ref_q      <= ref_eff;
                last_q     <= in_last;
                gain_div_q <= gain_div;
            end
        end
    end

    logic signed [DATA_W-1:0] peak_val;

    thermo_peak u_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (res_we),
        .last       (last_q),
        .value      (res_val),
        .peak_valid (out_max_valid),
        .peak       (peak_val)
    );

    assign out_max = peak_val;

    // R7: the result strobe lasts one cycle and the block is free again with it
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    a_r7_free_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !busy);

    // R9: a fault result carries zero
    a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_temp == '0));

    // R11: the group maximum is only reported alongside a result
    a_r11_max_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_max_valid |-> out_valid);

    // R8: state changes only on an accepted sample or a finished division
    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !div_done) |=> (state_q == $past(state_q)));

endmodule

// File: tb/thermo_cal_conv_tb_top.sv
`timescale 1ns/1ps
module thermo_cal_conv_tb_top;

    localparam int NSENS  = 6;
    localparam int IDX_W  = 3;
    localparam int INT_LO = -2147483647 - 1;
    localparam int LAT    = 66;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_valid = 1'b0;
    logic [9:0]  cal_gain_err = '0;
    logic [NSENS*9-1:0] cal_sensor_off = '0;
    logic [5:0]  cal_ref_temp = '0;
    logic [5:0]  cal_trim_mag = '0;
    logic cal_trim_sign = 1'b0;
    logic cal_chip_id = 1'b0;
    logic [7:0]  slope_const = 8'd165;
    logic in_valid = 1'b0;
    logic [IDX_W-1:0] in_idx = '0;
    logic [15:0] in_raw = '0;
    logic in_last = 1'b0;
    logic busy, out_valid, out_err, out_max_valid;
    logic [31:0] out_temp, out_max;

    always #2 clk = ~clk;

    thermo_cal_conv #(.NSENS(NSENS), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_valid(cal_valid), .cal_gain_err(cal_gain_err),
        .cal_sensor_off(cal_sensor_off), .cal_ref_temp(cal_ref_temp),
        .cal_trim_mag(cal_trim_mag), .cal_trim_sign(cal_trim_sign),
        .cal_chip_id(cal_chip_id), .slope_const(slope_const), .in_valid(in_valid),
        .in_idx(in_idx), .in_raw(in_raw), .in_last(in_last), .busy(busy),
        .out_valid(out_valid), .out_temp(out_temp), .out_err(out_err),
        .out_max_valid(out_max_valid), .out_max(out_max)
    );

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 1'b0;
    bit mon_on = 1'b0;
    string tag_t = "R7";
    string tag_v = "R3";

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural model of the conversion
    function automatic int model_conv(int raw12, int off, int ge, int refv, int d1);
        int t;
        t = 1627604160;
        t = t / d1;
        t = t / (10000 + ge);
        t = t * (raw12 - off - 3350);
        t = t >>> 3;
        return refv * 500 - t;
    endfunction

    int  cnt = 0;
    bit  pend = 1'b0;
    int  e_temp = 0;
    bit  e_err = 1'b0;
    bit  e_last = 1'b0;
    int  e_max = 0;
    int  acc = INT_LO;

    task automatic model_accept();
        int raw12, off, ge, refv, trim, d1, cl;
        raw12 = int'(in_raw) & 32'hfff;
        ge    = cal_valid ? int'(cal_gain_err) : 512;
        refv  = cal_valid ? int'(cal_ref_temp) : 40;
        off   = 260;
        if (cal_valid && int'(in_idx) < NSENS) off = int'(cal_sensor_off[int'(in_idx)*9 +: 9]);
        trim  = cal_valid ? int'(cal_trim_mag) : 0;
        if (cal_valid && cal_trim_sign && cal_chip_id) trim = -trim;
        d1 = int'(slope_const) + trim;
        if (d1 == 0) begin
            e_temp = 0; e_err = 1'b1; cnt = 2;
        end else begin
            e_temp = model_conv(raw12, off, ge, refv, d1); e_err = 1'b0; cnt = LAT + 1;
        end
        cl = (e_temp > 200000) ? 0 : e_temp;
        if (cl > acc) acc = cl;
        e_last = in_last;
        if (in_last) begin
            e_max = acc;
            acc = INT_LO;
        end
        pend = 1'b1;
    endtask

    // mid-cycle comparison on every clock
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on && !finished) begin
                bit exp_v;
                if (cnt > 0) cnt--;
                exp_v = pend && (cnt == 0);
                chk(out_valid == exp_v, tag_t, "out_valid", longint'(out_valid), longint'(exp_v));
                chk(busy == (cnt > 0), tag_t, "busy", longint'(busy), longint'(cnt > 0));
                if (exp_v) begin
                    pend = 1'b0;
                    chk($signed(out_temp) == e_temp, tag_v, "out_temp",
                        longint'($signed(out_temp)), longint'(e_temp));
                    chk(out_err == e_err, "R9", "out_err", longint'(out_err), longint'(e_err));
                    chk(out_max_valid == e_last, "R11", "out_max_valid",
                        longint'(out_max_valid), longint'(e_last));
                    if (e_last)
                        chk($signed(out_max) == e_max, "R11 R10", "out_max",
                            longint'($signed(out_max)), longint'(e_max));
                end
                if (in_valid && cnt == 0) model_accept();
            end
        end
    end

    task automatic send(input int idx, input int raw, input bit last);
        @(negedge clk);
        while (busy) @(negedge clk);
        in_idx   = IDX_W'(idx);
        in_raw   = 16'(raw);
        in_last  = last;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R12: reset state
        chk(out_valid == 1'b0, "R12", "out_valid", longint'(out_valid), 0);
        chk(out_temp == '0, "R12", "out_temp", longint'(out_temp), 0);
        chk(out_err == 1'b0, "R12", "out_err", longint'(out_err), 0);
        chk(out_max_valid == 1'b0, "R12", "out_max_valid", longint'(out_max_valid), 0);
        chk(out_max == '0, "R12", "out_max", longint'(out_max), 0);
        chk(busy == 1'b0, "R12", "busy", longint'(busy), 0);
        rst_n  = 1'b1;
        mon_on = 1'b1;

        // R5 R1 R10: defaults, masked upper raw bits, implausible values clamped
        tag_v = "R5 R1 R10";
        cal_valid = 1'b0; slope_const = 8'd165;
        cal_gain_err = 10'd999; cal_ref_temp = 6'd7; cal_trim_mag = 6'd30;
        send(0, 0, 1'b0);
        send(1, 16'hF800, 1'b0);
        send(2, 4095, 1'b1);
        drain();

        // R2 R3: calibrated conversion across several sensors
        tag_v = "R2 R3";
        cal_valid = 1'b1; cal_gain_err = 10'd300; cal_ref_temp = 6'd45;
        cal_sensor_off = {9'd280, 9'd255, 9'd240, 9'd265, 9'd270, 9'd250};
        cal_trim_mag = 6'd20; cal_trim_sign = 1'b1; cal_chip_id = 1'b0;
        send(0, 3000, 1'b0);
        send(3, 3500, 1'b0);
        send(5, 3900, 1'b0);
        send(1, 3200, 1'b1);
        drain();

        // R4: trim negated only with both sign and chip-id set
        tag_v = "R4";
        cal_trim_mag = 6'd25; cal_trim_sign = 1'b1; cal_chip_id = 1'b1;
        send(2, 3300, 1'b1);
        drain();
        cal_trim_sign = 1'b0; cal_chip_id = 1'b1;
        send(2, 3300, 1'b1);
        drain();
        slope_const = 8'd153; cal_trim_sign = 1'b1;
        send(4, 3700, 1'b1);
        drain();

        // R6: indices without a sensor use the default offset
        tag_v = "R6";
        slope_const = 8'd165;
        send(7, 3300, 1'b0);
        send(6, 2900, 1'b1);
        drain();

        // R11: all-negative group, maximum from the floor
        tag_v = "R11";
        cal_valid = 1'b0;
        send(0, 4000, 1'b0);
        send(1, 4095, 1'b0);
        send(2, 3900, 1'b1);
        drain();

        // R9: zero divisor fault followed by a normal sample in the same group
        tag_v = "R9";
        cal_valid = 1'b1; slope_const = 8'd40;
        cal_trim_mag = 6'd40; cal_trim_sign = 1'b1; cal_chip_id = 1'b1;
        send(0, 4000, 1'b0);
        drain();
        slope_const = 8'd165;
        send(1, 4000, 1'b1);
        drain();

        // R8: offers during busy are ignored
        tag_v = "R8";
        tag_t = "R8";
        cal_valid = 1'b0;
        send(0, 3100, 1'b1);
        repeat (5) @(negedge clk);
        in_idx = 3'd1; in_raw = 16'd123; in_last = 1'b0; in_valid = 1'b1;
        repeat (30) @(negedge clk);
        in_valid = 1'b0;
        drain();
        tag_t = "R7";

        // R7: back-to-back group latency
        tag_v = "R7";
        send(3, 3600, 1'b0);
        send(4, 3650, 1'b1);
        drain();

        summary();
    end

endmodule